// File: doc/BRIEF.md
# External Interrupt Controller with Claim/Complete

This block gathers level-sensitive interrupt requests from a set of peripheral sources and routes them to a small number of targets, one target per hart and privilege pair. Each source carries a 3-bit priority, and each target has its own enable mask and priority threshold. Every target drives one interrupt line. Software on a target reads a claim register to learn which source to serve, then writes that source ID back when servicing is done.

The register port is a plain 32-bit word interface. Reads return data on the cycle after the read strobe. A claim read has a side effect: it takes the chosen source out of the pending set and holds it in service. Target number `c` equals hart×2 + mode, where mode 0 is machine level and mode 1 is supervisor level. Bit `c` of `irqOut` is the line for target `c`.

Top module: `extIrqController`

## Requirements
- R1: Each source 1..NUM_SRC has a priority register at byte offset id×4 holding 3 bits (wider write data is truncated). ID 0 is not a source: its register reads 0 and ignores writes. A source of priority 0 is never signalled and never claimed.
- R2: `irqOut[c]` is high exactly when some source that is pending, enabled for target c, and of priority strictly greater than the threshold of target c exists. It reflects a register change from the cycle after the write edge.
- R3: A read of 0x200004 + c×0x1000 returns, on `regRdData` the cycle after `regRdEn`, the ID of the highest-priority eligible source for target c. Among equal priorities the lower ID wins.
- R4: A claim clears the chosen source's pending bit and marks it in service, so a later claim from any target does not return it.
- R5: A claim with no eligible source returns 0 and changes no state.
- R6: While a source is in service its pending bit is not set again, even if its input stays high. After completion, a source whose input is still high becomes pending on the next clock. A source whose input is low does not.
- R7: A write of ID s to 0x200004 + c×0x1000 ends the in-service state of s only if s is enabled for target c. Otherwise it is ignored.
- R8: The pending word at 0x1000 + w×4 shows source s at bit s mod 32 of word s/32, with bit 0 of word 0 always 0. Writes to it are ignored.
- R9: Target c has its enable words at 0x2000 + c×0x80 + w×4, where bit 0 of word 0 reads 0. It has its 3-bit threshold at 0x200000 + c×0x1000. Addresses outside the decoded regions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqSrc | input | NUM_SRC | Level request per source, bit s for source s (index NUM_SRC down to 1) |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, never together with a write |
| regAddr | input | 22 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after the read strobe |
| irqOut | output | NUM_CTX | Interrupt line per target |

## Verification
On every cycle the assertions check several properties. Each target line agrees with the arbiter's choice. A claimed source leaves pending and enters service. Nothing of priority 0 is ever claimed. Pending never rises on a source that was in service. A foreign completion leaves the in-service state untouched. A claim on a raised line returns a nonzero ID. Only the bench's scenarios can show the ordering choices: priority first, then lower ID on a tie. They also show the strict threshold comparison, the re-triggering of a still-high source after completion, and the readback values of the configuration registers.

// File: rtl/extIrqPkg.sv
package extIrqPkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } rdSel_e;

  typedef struct packed {
    logic   prioWr;
    logic   enWr;
    logic   thrWr;
    logic   complWr;
    logic   claimRd;
    logic   rdStb;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/extIrqControl.sv
module extIrqControl
  import extIrqPkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 4,
  parameter int ID_W    = $clog2(NUM_SRC + 1),
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int WORD_W  = (((NUM_SRC + 32) / 32) > 1) ? $clog2((NUM_SRC + 32) / 32) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [21:0]       regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  output strobe_t           stb,
  output logic [ID_W-1:0]   srcSel,
  output logic [CTX_W-1:0]  ctxSel,
  output logic [WORD_W-1:0] wordSel
);

  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;

  logic [9:0]  region;
  logic [9:0]  idField;
  logic [4:0]  enCtx;
  logic [4:0]  enWord;
  logic [8:0]  hiCtx;
  logic        aligned, ctxOk;
  logic        prioHit, pendHit, enHit, thrHit, clmHit;

  always_comb begin
    region  = regAddr[21:12];
    idField = regAddr[11:2];
    enCtx   = regAddr[11:7];
    enWord  = regAddr[6:2];
    hiCtx   = regAddr[20:12];
    aligned = (regAddr[1:0] == 2'b00);
    ctxOk   = (hiCtx < 9'(NUM_CTX));

    prioHit = (region == 10'd0) && aligned && (idField != 10'd0) &&
              (idField <= 10'(NUM_SRC));
    pendHit = (region == 10'd1) && aligned && (idField < 10'(NUM_WORDS));
    enHit   = (region == 10'd2) && aligned && (enCtx < 5'(NUM_CTX)) &&
              (enWord < 5'(NUM_WORDS));
    thrHit  = regAddr[21] && ctxOk && (regAddr[11:0] == 12'h000);
    clmHit  = regAddr[21] && ctxOk && (regAddr[11:0] == 12'h004);

    srcSel  = regAddr[ID_W+1:2];
    ctxSel  = regAddr[21] ? hiCtx[CTX_W-1:0] : enCtx[CTX_W-1:0];
    wordSel = (region == 10'd1) ? idField[WORD_W-1:0] : enWord[WORD_W-1:0];

    stb.prioWr  = regWrEn && prioHit;
    stb.enWr    = regWrEn && enHit;
    stb.thrWr   = regWrEn && thrHit;
    stb.complWr = regWrEn && clmHit;
    stb.claimRd = regRdEn && clmHit;
    stb.rdStb   = regRdEn;
    if (!regRdEn)     stb.rdSel = SEL_NONE;
    else if (prioHit) stb.rdSel = SEL_PRIO;
    else if (pendHit) stb.rdSel = SEL_PEND;
    else if (enHit)   stb.rdSel = SEL_EN;
    else if (thrHit)  stb.rdSel = SEL_THR;
    else if (clmHit)  stb.rdSel = SEL_CLAIM;
    else              stb.rdSel = SEL_NONE;
  end

  // R9: register regions never overlap
  assert_regions_disjoint_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prioHit, pendHit, enHit, thrHit, clmHit}));

endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 4,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = $clog2(NUM_SRC + 1),
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int WORD_W  = (((NUM_SRC + 32) / 32) > 1) ? $clog2((NUM_SRC + 32) / 32) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [ID_W-1:0]    srcSel,
  input  logic [CTX_W-1:0]   ctxSel,
  input  logic [WORD_W-1:0]  wordSel,
  input  logic [31:0]        wrData,
  input  logic [NUM_SRC:1]   irqSrc,
  output logic [31:0]        rdData,
  output logic [NUM_CTX-1:0] irqOut
);

  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int VEC_W     = NUM_WORDS * 32;

  logic [PRIO_W-1:0] prio [NUM_SRC:1];
  logic [NUM_SRC:1]  pend, inServ, claimHit, complHit;
  logic [NUM_SRC:1]  en [NUM_CTX];
  logic [PRIO_W-1:0] thr [NUM_CTX];
  logic [ID_W-1:0]   bestId [NUM_CTX];

  // Per-source storage and level gateway
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    assign claimHit[s] = stb.claimRd && (bestId[ctxSel] == ID_W'(s));
    assign complHit[s] = stb.complWr && (wrData == 32'(s)) && en[ctxSel][s];

    always_ff @(posedge clk) begin
      if (rst) prio[s] <= '0;
      else if (stb.prioWr && srcSel == ID_W'(s)) prio[s] <= wrData[PRIO_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)                             pend[s] <= 1'b0;
      else if (claimHit[s])                pend[s] <= 1'b0;
      else if (irqSrc[s] && !inServ[s])    pend[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)              inServ[s] <= 1'b0;
      else if (claimHit[s]) inServ[s] <= 1'b1;
      else if (complHit[s]) inServ[s] <= 1'b0;
    end

    assert_claim_takes_source_R4: assert property (@(posedge clk) disable iff (rst)
      claimHit[s] |=> (inServ[s] && !pend[s]));
    assert_no_zero_prio_claim_R1: assert property (@(posedge clk) disable iff (rst)
      claimHit[s] |-> (prio[s] != '0));
    assert_hold_in_service_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[s]) |-> !$past(inServ[s]));
    assert_ignore_foreign_complete_R7: assert property (@(posedge clk) disable iff (rst)
      (stb.complWr && wrData == 32'(s) && !en[ctxSel][s] && inServ[s]) |=> inServ[s]);
  end

  // Per-target enable, threshold, arbitration and line
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [NUM_SRC:1]  aboveThr;
    logic [PRIO_W-1:0] bestPrio;

    always_ff @(posedge clk) begin
      if (rst) en[c] <= '0;
      else if (stb.enWr && ctxSel == CTX_W'(c)) begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (WORD_W'(s / 32) == wordSel) en[c][s] <= wrData[s % 32];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) thr[c] <= '0;
      else if (stb.thrWr && ctxSel == CTX_W'(c)) thr[c] <= wrData[PRIO_W-1:0];
    end

    always_comb begin
      bestId[c] = '0;
      bestPrio  = thr[c];
      for (int s = 1; s <= NUM_SRC; s++) begin
        aboveThr[s] = (prio[s] > thr[c]);
        if (pend[s] && en[c][s] && prio[s] > bestPrio) begin
          bestId[c] = ID_W'(s);
          bestPrio  = prio[s];
        end
      end
    end

    assign irqOut[c] = |(pend & en[c] & aboveThr);

    assert_line_matches_choice_R2: assert property (@(posedge clk) disable iff (rst)
      irqOut[c] == (bestId[c] != '0));
    assert_claim_returns_id_R3: assert property (@(posedge clk) disable iff (rst)
      (stb.claimRd && ctxSel == CTX_W'(c) && irqOut[c]) |=> (rdData != 32'd0));
  end

  // Read path
  logic [VEC_W-1:0] padPend, padEn;
  logic [31:0]      rdNext;

  always_comb begin
    padPend = '0;
    padPend[NUM_SRC:1] = pend;
    padEn = '0;
    padEn[NUM_SRC:1] = en[ctxSel];
    case (stb.rdSel)
      SEL_PRIO:  rdNext = 32'(prio[srcSel]);
      SEL_PEND:  rdNext = padPend[{wordSel, 5'b0} +: 32];
      SEL_EN:    rdNext = padEn[{wordSel, 5'b0} +: 32];
      SEL_THR:   rdNext = 32'(thr[ctxSel]);
      SEL_CLAIM: rdNext = 32'(bestId[ctxSel]);
      default:   rdNext = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= 32'd0;
    else if (stb.rdStb) rdData <= rdNext;
  end

endmodule

// File: rtl/extIrqController.sv
module extIrqController
  import extIrqPkg::*;
#(
  parameter int NUM_SRC  = 31,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 3,
  parameter int NUM_CTX  = NUM_HART * 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   irqSrc,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [21:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic [NUM_CTX-1:0] irqOut
);

  localparam int ID_W      = $clog2(NUM_SRC + 1);
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  strobe_t           stb;
  logic [ID_W-1:0]   srcSel;
  logic [CTX_W-1:0]  ctxSel;
  logic [WORD_W-1:0] wordSel;

  extIrqControl #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .ID_W(ID_W), .CTX_W(CTX_W), .WORD_W(WORD_W)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .stb(stb), .srcSel(srcSel), .ctxSel(ctxSel), .wordSel(wordSel)
  );

  extIrqDatapath #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W),
    .ID_W(ID_W), .CTX_W(CTX_W), .WORD_W(WORD_W)
  ) uData (
    .clk(clk), .rst(rst),
    .stb(stb), .srcSel(srcSel), .ctxSel(ctxSel), .wordSel(wordSel),
    .wrData(regWrData), .irqSrc(irqSrc),
    .rdData(regRdData), .irqOut(irqOut)
  );

endmodule

// File: tb/extIrqController_test.sv
module extIrqController_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 31;
  localparam int NCTX = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC:1]     irqSrc = '0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [21:0]       regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [NCTX-1:0]   irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extIrqController #(.NUM_SRC(NSRC), .NUM_HART(2)) uut (
    .clk(clk), .rst(rst), .irqSrc(irqSrc),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [21:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 22'h00000C, 32'h5,        32'h0,        4'd1},
    '{1'b0, 22'h00000C, 32'h0,        32'h5,        4'd1},  // R1 readback
    '{1'b1, 22'h00000C, 32'hFF,       32'h0,        4'd1},
    '{1'b0, 22'h00000C, 32'h0,        32'h7,        4'd1},  // R1 truncation
    '{1'b1, 22'h000000, 32'h7,        32'h0,        4'd1},
    '{1'b0, 22'h000000, 32'h0,        32'h0,        4'd1},  // R1 id 0 not a source
    '{1'b1, 22'h002000, 32'hFFFFFFFF, 32'h0,        4'd9},
    '{1'b0, 22'h002000, 32'h0,        32'hFFFFFFFE, 4'd9},  // R9 enable bit 0
    '{1'b1, 22'h201000, 32'h9,        32'h0,        4'd9},
    '{1'b0, 22'h201000, 32'h0,        32'h1,        4'd9},  // R9 threshold 3 bits
    '{1'b1, 22'h001000, 32'hFFFF,     32'h0,        4'd8},
    '{1'b0, 22'h001000, 32'h0,        32'h0,        4'd8},  // R8 write ignored
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd5},  // R5 empty claim
    '{1'b1, 22'h002080, 32'h88,       32'h0,        4'd9},
    '{1'b0, 22'h002080, 32'h0,        32'h88,       4'd9}   // R9 target 1 enable
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [21:0] claimAddr(input int c);
    return 22'(32'h200004 + c * 32'h1000);
  endfunction

  function automatic logic [21:0] thrAddr(input int c);
    return 22'(32'h200000 + c * 32'h1000);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitCycles(3);
    rst = 1'b0;
    waitCycles(1);
    check("R2 reset lines", 32'(irqOut), 32'h0);
    check("R3 reset read data", regRdData, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) regWrite(VECS[i].addr, VECS[i].data);
      else begin
        regRead(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // Setup: priorities and thresholds
    regWrite(22'h00000C, 5);   // src 3
    regWrite(22'h00001C, 5);   // src 7
    regWrite(22'h000024, 2);   // src 9
    regWrite(22'h000050, 6);   // src 20
    regWrite(thrAddr(0), 0);
    regWrite(thrAddr(1), 0);

    // R1: priority 0 source is never signalled
    irqSrc[12] = 1'b1;
    waitCycles(2);
    check("R1 prio0 line", 32'(irqOut), 32'h0);
    regRead(claimAddr(0), rd);
    check("R1 prio0 claim", rd, 32'h0);

    // R2: line follows eligibility and strict threshold
    irqSrc[9] = 1'b1;
    waitCycles(2);
    check("R2 line target0", 32'(irqOut[0]), 32'h1);
    check("R2 line target1 not enabled", 32'(irqOut[1]), 32'h0);
    regWrite(thrAddr(0), 2);
    check("R2 equal threshold masks", 32'(irqOut[0]), 32'h0);
    regWrite(thrAddr(0), 1);
    check("R2 lower threshold passes", 32'(irqOut[0]), 32'h1);

    // R3: higher priority wins over lower id
    irqSrc[20] = 1'b1;
    waitCycles(2);
    regRead(claimAddr(0), rd);
    check("R3 highest priority", rd, 32'd20);
    regRead(22'h001000, rd);
    check("R4 claim clears pending", rd, (32'h1 << 9) | (32'h1 << 12));

    // R3: tie goes to lower id
    irqSrc[3] = 1'b1;
    irqSrc[7] = 1'b1;
    waitCycles(2);
    check("R2 target1 line", 32'(irqOut[1]), 32'h1);
    regRead(claimAddr(0), rd);
    check("R3 tie lower id", rd, 32'd3);

    // R4: other target cannot take the in-service source
    regRead(claimAddr(1), rd);
    check("R4 other target gets next", rd, 32'd7);
    regRead(claimAddr(1), rd);
    check("R5 nothing eligible", rd, 32'd0);
    waitCycles(1);
    check("R4 target1 line drops", 32'(irqOut[1]), 32'h0);

    // R6: in-service sources stay out of pending
    waitCycles(2);
    regRead(22'h001000, rd);
    check("R6 held while in service", rd, (32'h1 << 9) | (32'h1 << 12));

    // R7: completion through a target without the enable is ignored
    regWrite(claimAddr(2), 3);
    waitCycles(2);
    regRead(22'h001000, rd);
    check("R7 foreign completion ignored", rd, (32'h1 << 9) | (32'h1 << 12));

    // R6: completion re-arms a still-high source
    regWrite(claimAddr(0), 3);
    waitCycles(2);
    regRead(22'h001000, rd);
    check("R6 retrigger after completion", rd, (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 12));

    // R6: low input after completion stays idle
    irqSrc[20] = 1'b0;
    regWrite(claimAddr(0), 20);
    waitCycles(2);
    regRead(22'h001000, rd);
    check("R6 no retrigger when low", rd, (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 12));

    // R3/R5: drain remaining sources on target 0
    regRead(claimAddr(0), rd);
    check("R3 drain first", rd, 32'd3);
    regRead(claimAddr(0), rd);
    check("R3 drain second", rd, 32'd9);
    regRead(claimAddr(0), rd);
    check("R5 drain empty", rd, 32'd0);
    waitCycles(1);
    check("R2 all lines low", 32'(irqOut), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

endmodule